// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Timer

This peripheral generates several pulse-width-modulated outputs from a single up-counter. A power-of-two prescaler slows the input clock into counting ticks, and the counter climbs from zero to a programmable 16-bit modulo before it wraps, so every output shares one period. Each channel has its own compare value and its own control byte. The compare value sets the duty and the control byte picks the output behaviour: high-true PWM, inverted PWM, or off.

Software reaches the block through a flat register port. Writes take one cycle and reads are combinational. The run state is a two-state machine: `ST_HALT` and `ST_RUN`. The transition START (`ST_HALT`→`ST_RUN`) happens on the cycle after the clock-mode field becomes 01. The transition STOP (`ST_RUN`→`ST_HALT`) happens on the cycle after the clock-mode field takes any other value. Several settings depend on this state. While halted, the prescale field, the modulo and the compare values are accepted at once. While running, the prescale field is locked, and modulo and compare updates wait for the next wrap so that no period is cut short.

Top module: `pwm_shared_timer`

## Requirements
- R1: The read-only word at offset 0x04 returns the channel count in bits [7:0]. Writes to it have no effect.
- R2: At offset 0x10, bits [2:0] hold the prescale exponent and bits [4:3] hold the clock mode. Mode 01 runs the counter and any other value halts it. Bit 5 is ignored and reads 0.
- R3: The prescale exponent can only be changed while halted; a write made while running keeps the old value. While running, the counter advances once every 2^exponent input clocks.
- R4: The counter at offset 0x14 counts from 0 up to the modulo inclusive and then returns to 0. The period is therefore (modulo+1)·2^exponent clocks.
- R5: The modulo at offset 0x18 is 16 bits wide. A write made while halted applies at once. A write made while running applies at the next wrap, and until then reads return the old value.
- R6: Any write to the counter register clears the counter to 0.
- R7: Channel n has its control byte at 0x20+8n and its compare value at 0x24+8n. In the control byte, bit 5 set with bit 4 clear selects PWM. The edge-level field [3:2] is then decoded: 2'b10 gives normal output and 2'b01 gives inverted output. Every other combination disables the channel and drives its output low.
- R8: In normal polarity the output is high while the counter is below the compare value and low otherwise. A compare value of 0 keeps the output low, and a compare value above the modulo keeps it high for the whole period. Inverted polarity is the exact complement.
- R9: A compare write made while halted applies at once. A compare write made while running applies at the next wrap. Reads return the last written value.
- R10: While halted, the counter and every enabled output hold their values.
- R11: Bit 7 of a channel control byte is set at a wrap if the counter equalled that channel's active compare value during the period that is ending. Writing 1 to bit 7 clears it, and writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pwm_out | output | NUM_CH | One registered PWM output per channel |

## Verification
The in-RTL properties check, on every cycle, the invariants that hold cycle by cycle. A disabled channel is low on the next cycle. A halted timer keeps its outputs and its count. A clear or a wrap returns the counter to zero. The prescale field and the active modulo do not move while the timer is running. A match seen during a period raises the flag at the wrap. Other behaviours only show up when the bench drives whole scenarios and counts high cycles over complete periods. These are the duty produced by each polarity and compare corner, the stretched period that a prescale setting gives, and deferred modulo and compare values reaching the waveform.

// File: rtl/pwmt_pkg.sv
`timescale 1ns/1ps
package pwmt_pkg;
    localparam int unsigned CNT_W       = 16;
    localparam int unsigned PS_W        = 3;
    localparam int unsigned OFS_INFO    = 32'h04;
    localparam int unsigned OFS_SC      = 32'h10;
    localparam int unsigned OFS_COUNT   = 32'h14;
    localparam int unsigned OFS_MOD     = 32'h18;
    localparam int unsigned OFS_CH_BASE = 32'h20;
    localparam int unsigned CH_STRIDE   = 8;

    typedef enum logic [1:0] {
        CLK_OFF  = 2'b00,
        CLK_TICK = 2'b01
    } clk_mode_e;

    localparam logic [1:0] LVL_INV  = 2'b01;
    localparam logic [1:0] LVL_NORM = 2'b10;
    localparam logic [1:0] MODE_PWM = 2'b10;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/pwmt_prescaler.sv
`timescale 1ns/1ps
module pwmt_prescaler #(
    parameter int unsigned PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    localparam int unsigned DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] limit;

    assign limit = ~({DIV_W{1'b1}} << ps);
    assign tick  = run && (div_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            div_q <= '0;
        else if (!run || tick) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
    end

    // R3: no tick while halted
    a_r3_no_tick_halted: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);
endmodule

// File: rtl/pwmt_counter.sv
`timescale 1ns/1ps
module pwmt_counter
    import pwmt_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    clk_mode,
    input  logic          tick,
    input  logic          mod_we,
    input  logic [CW-1:0] mod_wdata,
    input  logic          cnt_clr,
    output logic          run,
    output logic          wrap,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] mod_act
);
    run_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, mod_q, mod_pend_q;
    logic          pend_v_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HALT: if (clk_mode == CLK_TICK) st_d = ST_RUN;
            ST_RUN:  if (clk_mode != CLK_TICK) st_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HALT;
        else        st_q <= st_d;
    end

    assign run     = (st_q == ST_RUN);
    assign wrap    = tick && (cnt_q >= mod_q);
    assign cnt     = cnt_q;
    assign mod_act = mod_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (cnt_clr) cnt_q <= '0;
        else if (wrap)    cnt_q <= '0;
        else if (tick)    cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_q      <= '0;
            mod_pend_q <= '0;
            pend_v_q   <= 1'b0;
        end else if (mod_we && !run) begin
            mod_q    <= mod_wdata;
            pend_v_q <= 1'b0;
        end else begin
            if (wrap && pend_v_q) begin
                mod_q    <= mod_pend_q;
                pend_v_q <= 1'b0;
            end
            if (mod_we) begin
                mod_pend_q <= mod_wdata;
                pend_v_q   <= 1'b1;
            end
        end
    end

    // R6: counter write clears
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (cnt_q == '0));
    // R4: wrap returns to zero
    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0));
    // R10: halted counter frozen
    a_r10_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_clr) |=> $stable(cnt_q));
    // R5: running modulo write deferred
    a_r5_mod_deferred: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_we && run && !wrap) |=> $stable(mod_q));
endmodule

// File: rtl/pwmt_channel.sv
`timescale 1ns/1ps
module pwmt_channel
    import pwmt_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          wrap,
    input  logic [CW-1:0] cnt,
    input  logic          ctrl_we,
    input  logic          val_we,
    input  logic [CW-1:0] wdata,
    output logic [7:0]    ctrl_rd,
    output logic [CW-1:0] val_rd,
    output logic          pwm_o
);
    logic [1:0]    mode_q, lvl_q;
    logic          flag_q, hit_q, out_q, en, match;
    logic [CW-1:0] cv_q, cv_buf_q;

    assign en      = (mode_q == MODE_PWM) && ((lvl_q == LVL_NORM) || (lvl_q == LVL_INV));
    assign match   = run && (cnt == cv_q);
    assign ctrl_rd = {flag_q, 1'b0, mode_q, lvl_q, 2'b00};
    assign val_rd  = cv_buf_q;
    assign pwm_o   = out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            lvl_q    <= '0;
            flag_q   <= 1'b0;
            hit_q    <= 1'b0;
            cv_q     <= '0;
            cv_buf_q <= '0;
        end else begin
            if (ctrl_we) begin
                mode_q <= wdata[5:4];
                lvl_q  <= wdata[3:2];
            end
            if (wrap && (hit_q || match))  flag_q <= 1'b1;
            else if (ctrl_we && wdata[7])  flag_q <= 1'b0;
            if (wrap)       hit_q <= 1'b0;
            else if (match) hit_q <= 1'b1;
            if (val_we) cv_buf_q <= wdata;
            if (val_we && !run) cv_q <= wdata;
            else if (wrap)      cv_q <= cv_buf_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   out_q <= 1'b0;
        else if (!en) out_q <= 1'b0;
        else if (run) out_q <= (lvl_q == LVL_INV) ^ (cnt < cv_q);
    end

    // R7: disabled channel drives low
    a_r7_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwm_o);
    // R10: halted output holds
    a_r10_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !run) |=> $stable(pwm_o));
    // R11: match during period raises flag at wrap
    a_r11_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && hit_q) |=> flag_q);
    // R8: zero compare keeps normal output low
    a_r8_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (en && run && lvl_q == LVL_NORM && cv_q == '0) |=> !pwm_o);
endmodule

// File: rtl/pwm_shared_timer.sv
`timescale 1ns/1ps
module pwm_shared_timer
    import pwmt_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int unsigned CW = CNT_W;

    logic [PS_W-1:0] ps_q;
    logic [1:0]      cmode_q;
    logic            sc_we, mod_we, cnt_clr, run, tick, wrap;
    logic [CW-1:0]   cnt, mod_act;
    logic [NUM_CH-1:0] ch_ctrl_we, ch_val_we;
    logic [7:0]      ch_ctrl_rd [NUM_CH];
    logic [CW-1:0]   ch_val_rd  [NUM_CH];

    assign sc_we   = reg_we && (reg_addr == ADDR_W'(OFS_SC));
    assign mod_we  = reg_we && (reg_addr == ADDR_W'(OFS_MOD));
    assign cnt_clr = reg_we && (reg_addr == ADDR_W'(OFS_COUNT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q    <= '0;
            cmode_q <= CLK_OFF;
        end else if (sc_we) begin
            cmode_q <= reg_wdata[4:3];
            if (!run) ps_q <= reg_wdata[PS_W-1:0];
        end
    end

    pwmt_prescaler #(.PS_W(PS_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run), .ps(ps_q), .tick(tick)
    );

    pwmt_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clk_mode(cmode_q), .tick(tick),
        .mod_we(mod_we), .mod_wdata(reg_wdata[CW-1:0]), .cnt_clr(cnt_clr),
        .run(run), .wrap(wrap), .cnt(cnt), .mod_act(mod_act)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign ch_ctrl_we[g] = reg_we && (reg_addr == ADDR_W'(OFS_CH_BASE + CH_STRIDE*g));
        assign ch_val_we[g]  = reg_we && (reg_addr == ADDR_W'(OFS_CH_BASE + CH_STRIDE*g + 4));
        pwmt_channel #(.CW(CW)) u_ch (
            .clk(clk), .rst_n(rst_n), .run(run), .wrap(wrap), .cnt(cnt),
            .ctrl_we(ch_ctrl_we[g]), .val_we(ch_val_we[g]),
            .wdata(reg_wdata[CW-1:0]), .ctrl_rd(ch_ctrl_rd[g]),
            .val_rd(ch_val_rd[g]), .pwm_o(pwm_out[g])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFS_INFO))       reg_rdata[7:0] = 8'(NUM_CH);
        else if (reg_addr == ADDR_W'(OFS_SC))    reg_rdata[4:0] = {cmode_q, ps_q};
        else if (reg_addr == ADDR_W'(OFS_COUNT)) reg_rdata[CW-1:0] = cnt;
        else if (reg_addr == ADDR_W'(OFS_MOD))   reg_rdata[CW-1:0] = mod_act;
        for (int i = 0; i < NUM_CH; i++) begin
            if (reg_addr == ADDR_W'(OFS_CH_BASE + CH_STRIDE*i))
                reg_rdata[7:0] = ch_ctrl_rd[i];
            if (reg_addr == ADDR_W'(OFS_CH_BASE + CH_STRIDE*i + 4))
                reg_rdata[CW-1:0] = ch_val_rd[i];
        end
    end

    // R3: prescale locked while running
    a_r3_ps_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_we && run) |=> $stable(ps_q));
    // R2: run state follows clock mode one cycle later
    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cmode_q == CLK_TICK) |=> run);
endmodule

// File: tb/test_pwm_shared_timer.sv
`timescale 1ns/1ps
module test_pwm_shared_timer;
    localparam int NCH = 4;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NCH-1:0] pwm_out;
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwm_shared_timer #(.NUM_CH(NCH), .ADDR_W(8)) i_pwm_shared_timer (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
    );

    // {req code, addr, write data, expected readback}
    localparam logic [43:0] VEC [8] = '{
        {4'd1, 8'h04, 16'h0055, 16'h0004},
        {4'd5, 8'h18, 16'h0009, 16'h0009},
        {4'd2, 8'h10, 16'h0025, 16'h0005},
        {4'd7, 8'h20, 16'h0028, 16'h0028},
        {4'd9, 8'h24, 16'h0003, 16'h0003},
        {4'd7, 8'h28, 16'h0024, 16'h0024},
        {4'd11,8'h30, 16'h00FF, 16'h003C},
        {4'd2, 8'h10, 16'h0000, 16'h0000}
    };

    function automatic string rq(input logic [3:0] c);
        case (c)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd5: return "R5";
            4'd7: return "R7";
            4'd9: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic highs(input int ch, input int n, output int h);
        h = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm_out[ch]) h++;
        end
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        int h;
        logic [NCH-1:0] held;
        bit same;
        idle(3);
        rst_n = 1'b1;
        // reset state (R2, R4, R5, R7)
        rd(8'h10, v); chk("R2", v, 32'h0);
        rd(8'h14, v); chk("R4", v, 32'h0);
        rd(8'h18, v); chk("R5", v, 32'h0);
        chk("R7", 32'(pwm_out), 32'h0);

        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][39:32], 32'(VEC[i][31:16]));
            rd(VEC[i][39:32], v);
            chk(rq(VEC[i][43:40]), v, 32'(VEC[i][15:0]));
        end

        // period 10: ch0 normal cv3, ch1 inverted cv3, ch2 cv0, ch3 cv above modulo
        wr(8'h18, 9);
        wr(8'h20, 32'h28); wr(8'h24, 3);
        wr(8'h28, 32'h24); wr(8'h2C, 3);
        wr(8'h30, 32'h28); wr(8'h34, 0);
        wr(8'h38, 32'h28); wr(8'h3C, 12);
        wr(8'h10, 32'h08);
        idle(30);
        highs(0, 10, h); chk("R8", 32'(h), 32'd3);
        highs(1, 10, h); chk("R8", 32'(h), 32'd7);
        highs(2, 10, h); chk("R8", 32'(h), 32'd0);
        highs(3, 10, h); chk("R8", 32'(h), 32'd10);
        rd(8'h20, v); chk("R11", v, 32'hA8);

        // R3: prescale write while running ignored
        wr(8'h10, 32'h0B);
        rd(8'h10, v); chk("R3", v, 32'h08);

        // R5: modulo while running deferred to wrap
        wr(8'h18, 19);
        rd(8'h18, v); chk("R5", v, 32'd9);
        idle(30);
        rd(8'h18, v); chk("R5", v, 32'd19);
        highs(0, 20, h); chk("R4", 32'(h), 32'd3);

        // R9: compare while running
        wr(8'h24, 5);
        rd(8'h24, v); chk("R9", v, 32'd5);
        idle(25);
        highs(0, 20, h); chk("R9", 32'(h), 32'd5);

        // R7: disable via edge-level 00 and 11
        wr(8'h20, 32'h20); idle(3);
        highs(0, 20, h); chk("R7", 32'(h), 32'd0);
        wr(8'h20, 32'h2C); idle(3);
        highs(0, 20, h); chk("R7", 32'(h), 32'd0);

        // R10: halt holds outputs and count
        wr(8'h10, 32'h00); idle(5);
        held = pwm_out;
        same = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (pwm_out !== held) same = 1'b0;
        end
        chk("R10", 32'(same), 32'd1);
        rd(8'h14, v); idle(7); rd(8'h14, v2);
        chk("R10", v2, v);

        // R6: counter clear
        wr(8'h14, 32'h1234);
        rd(8'h14, v); chk("R6", v, 32'h0);

        // R11: flag set and write-one clear
        rd(8'h28, v); chk("R11", v, 32'hA4);
        wr(8'h28, 32'hA4);
        rd(8'h28, v); chk("R11", v, 32'h24);

        // R3: prescale 1 accepted while halted, period doubled to 40
        wr(8'h10, 32'h09);
        rd(8'h10, v); chk("R3", v, 32'h09);
        idle(80);
        highs(3, 40, h); chk("R3", 32'(h), 32'd24);
        highs(1, 40, h); chk("R8", 32'(h), 32'd34);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule